// File: doc/BRIEF.md
# Thermal-Model Burst Guard

This block sits on one output channel, after the pulse generator. It keeps a scaled heat figure in a 40-bit accumulator. Every pulse it lets through adds a fixed increment to that figure. While the channel is idle, the figure is lowered at regular intervals by steps read from a 16-entry decay table. The longer the channel has been quiet, the further along the table the step is taken. Because of this, a short run of closely spaced pulses passes untouched, but a sustained high-rate stream drives the figure up to its ceiling.

The decision is made on the pulse's rising-edge strobe. If adding the increment would take the figure above the ceiling, the whole pulse is blanked until its falling-edge strobe, the figure is left as it was, and a single-cycle error strobe is raised. Passed pulses come out exactly one clock later than they arrive. The increment, the ceiling, the decay table and the idle interval are parameters. The package holds the constants for narrow and wide pulses, and a single parameter picks between them.

Top module: `burst_heat_guard`

## Requirements
- R1: After reset both outputs are low, the heat figure is zero and the idle interval counter and decay index are zero.
- R2: A pulse that is not suppressed appears on `pulse_o` delayed by exactly one clock cycle, cycle for cycle.
- R3: On a rising-edge strobe whose pulse is passed, the heat figure rises by exactly `HEAT_INC`. Nothing else raises it.
- R4: If the heat figure plus `HEAT_INC` is greater than `HEAT_MAX` on a rising-edge strobe, `pulse_o` stays low from that pulse's first cycle through its falling-edge strobe, and the heat figure is not changed.
- R5: A suppressed pulse raises `err_p_o` for exactly one cycle, in the cycle where its first output cycle would have been. A passed pulse never raises it.
- R6: The idle interval counter advances only in cycles with `pulse_i` low. It holds while `pulse_i` is high. Every `IDLE_CYCLES` idle cycles it marks an interval boundary.
- R7: At each interval boundary, the step `DECAY_STEPS[n]` is subtracted, where n is the number of boundaries since the last rising-edge strobe, capped at 15 (entry 0 is the left-most table element). A rising-edge strobe sets n and the interval counter back to zero.
- R8: A decay step larger than the heat figure leaves the figure at zero; it never wraps.
- R9: When a rising-edge strobe and a falling-edge strobe arrive in the same cycle, the new pulse's decision wins: a suppressed new pulse is blanked from that cycle, even if the previous pulse was passed.
- R10: A sum equal to `HEAT_MAX` is allowed; the pulse passes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pulse_i | input | 1 | Pulse from the generator |
| rise_p_i | input | 1 | Single-cycle strobe on the pulse's first high cycle |
| fall_p_i | input | 1 | Single-cycle strobe marking the pulse's end |
| pulse_o | output | 1 | Gated pulse, one cycle behind `pulse_i` |
| err_p_o | output | 1 | Single-cycle strobe for a pulse blanked by the heat limit |

## Verification
Two events can land in the same cycle. The falling-edge strobe of a passed pulse can coincide with the rising-edge strobe of a pulse that is over the limit. The bench provokes this by raising both strobes together while `pulse_i` stays high. It then expects the second pulse to be blanked for its full length and a single error strobe. A reference model in the scoreboard tracks the heat figure, the decay index and the interval counter from the requirements. Long idle stretches past sixteen boundaries check the index cap and the floor at zero.

// File: rtl/bhg_pkg.sv
package bhg_pkg;

    // Entry 0 is the left-most element of the assignment pattern.
    typedef logic [0:15][31:0] bhg_decay_t;

    localparam bhg_decay_t BHG_DECAY_NARROW =
        '{32'd0, 32'd0, 32'd769, 32'd31, 32'd104, 32'd14, 32'd82, 32'd0,
          32'd0, 32'd0, 32'd0, 32'd0, 32'd0, 32'd0, 32'd0, 32'd0};

    localparam bhg_decay_t BHG_DECAY_WIDE =
        '{32'd0, 32'd0, 32'd0, 32'd0, 32'd0, 32'd0, 32'd0, 32'd0,
          32'd5750, 32'd100, 32'd79, 32'd13, 32'd12, 32'd4, 32'd5, 32'd13};

    localparam logic [19:0] BHG_INC_NARROW = 20'h01388;
    localparam logic [19:0] BHG_INC_WIDE   = 20'h17700;
    localparam logic [39:0] BHG_HEAT_MAX   = 40'h02540BE400;

    localparam int unsigned BHG_IDX_LAST = 15;

endpackage

// File: rtl/bhg_idle_sched.sv
module bhg_idle_sched
    import bhg_pkg::*;
#(
    parameter int unsigned IDLE_CYCLES = 20,
    parameter bhg_decay_t  DECAY_STEPS = BHG_DECAY_NARROW
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pulse_i,
    input  logic        rise_p_i,
    output logic        tick_o,
    output logic [31:0] step_o
);
    localparam int unsigned CW = (IDLE_CYCLES > 1) ? $clog2(IDLE_CYCLES) : 1;
    localparam logic [CW-1:0] CYC_LAST = CW'(IDLE_CYCLES - 1);

    typedef struct packed {
        logic [CW-1:0] cyc;
        logic [3:0]    idx;
    } sched_t;

    sched_t s_d, s_q;
    logic   tick_d;
    logic [3:0] idx_nx;

    always_comb begin
        s_d    = s_q;
        tick_d = 1'b0;
        idx_nx = (s_q.idx == 4'(BHG_IDX_LAST)) ? s_q.idx : s_q.idx + 4'd1;
        if (rise_p_i) begin
            s_d.cyc = '0;
            s_d.idx = '0;
        end else if (!pulse_i) begin
            if (s_q.cyc == CYC_LAST) begin
                s_d.cyc = '0;
                s_d.idx = idx_nx;
                tick_d  = 1'b1;
            end else begin
                s_d.cyc = s_q.cyc + 1'b1;
            end
        end
    end

    assign tick_o = tick_d;
    assign step_o = tick_d ? DECAY_STEPS[idx_nx] : 32'd0;

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R6: the interval counter never moves while a pulse is high
    a_r6_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pulse_i) && !$past(rise_p_i)) |-> $stable(s_q.cyc));

    // R7: a rising strobe restarts the decay index
    a_r7_index_restart: assert property (@(posedge clk) disable iff (!rst_n)
        rise_p_i |=> (s_q.idx == 4'd0));

endmodule

// File: rtl/bhg_heat_acc.sv
module bhg_heat_acc #(
    parameter int unsigned   ACC_W    = 40,
    parameter logic [19:0]   HEAT_INC = 20'h01388,
    parameter logic [39:0]   HEAT_MAX = 40'h02540BE400
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rise_p_i,
    input  logic        tick_i,
    input  logic [31:0] step_i,
    output logic        over_o
);
    localparam int unsigned SW = ACC_W + 1;

    typedef struct packed {
        logic [ACC_W-1:0] heat;
    } acc_t;

    acc_t s_d, s_q;
    logic [SW-1:0]    sum;
    logic [ACC_W-1:0] step_ext;
    logic             over;

    always_comb begin
        sum      = {1'b0, s_q.heat} + SW'(HEAT_INC);
        over     = sum > SW'(HEAT_MAX);
        step_ext = ACC_W'(step_i);
        s_d      = s_q;
        if (rise_p_i) begin
            if (!over) s_d.heat = sum[ACC_W-1:0];
        end else if (tick_i) begin
            s_d.heat = (s_q.heat > step_ext) ? s_q.heat - step_ext : '0;
        end
    end

    assign over_o = over;

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R4: the figure never sits above the ceiling
    a_r4_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
        SW'(s_q.heat) <= SW'(HEAT_MAX));

    // R3: only a rising strobe raises the figure
    a_r3_rise_only: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.heat > $past(s_q.heat)) |-> $past(rise_p_i));

    // R8: the figure falls only at an interval boundary
    a_r8_fall_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.heat < $past(s_q.heat)) |-> $past(tick_i));

endmodule

// File: rtl/burst_heat_guard.sv
module burst_heat_guard
    import bhg_pkg::*;
#(
    parameter bit          WIDE_PULSES = 1'b0,
    parameter int unsigned ACC_W       = 40,
    parameter logic [19:0] HEAT_INC    = WIDE_PULSES ? BHG_INC_WIDE : BHG_INC_NARROW,
    parameter logic [39:0] HEAT_MAX    = BHG_HEAT_MAX,
    parameter int unsigned IDLE_CYCLES = 20,
    parameter bhg_decay_t  DECAY_STEPS = WIDE_PULSES ? BHG_DECAY_WIDE : BHG_DECAY_NARROW
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse_i,
    input  logic rise_p_i,
    input  logic fall_p_i,
    output logic pulse_o,
    output logic err_p_o
);
    typedef struct packed {
        logic pass;
        logic err;
        logic mask;
    } gate_t;

    gate_t       g_d, g_q;
    logic        tick;
    logic [31:0] step;
    logic        over;
    logic        blank;

    bhg_idle_sched #(
        .IDLE_CYCLES (IDLE_CYCLES),
        .DECAY_STEPS (DECAY_STEPS)
    ) u_sched (
        .clk      (clk),
        .rst_n    (rst_n),
        .pulse_i  (pulse_i),
        .rise_p_i (rise_p_i),
        .tick_o   (tick),
        .step_o   (step)
    );

    bhg_heat_acc #(
        .ACC_W    (ACC_W),
        .HEAT_INC (HEAT_INC),
        .HEAT_MAX (HEAT_MAX)
    ) u_heat (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise_p_i (rise_p_i),
        .tick_i   (tick),
        .step_i   (step),
        .over_o   (over)
    );

    always_comb begin
        blank      = rise_p_i ? over : g_q.mask;
        g_d.pass   = pulse_i & ~blank;
        g_d.err    = rise_p_i & over;
        if (rise_p_i)      g_d.mask = over;
        else if (fall_p_i) g_d.mask = 1'b0;
        else               g_d.mask = g_q.mask;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    assign pulse_o = g_q.pass;
    assign err_p_o = g_q.err;

    // R2: output high only where the input was high one cycle earlier
    a_r2_one_cycle_lag: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |-> $past(pulse_i));

    // R5: the error strobe lasts one cycle
    a_r5_err_single: assert property (@(posedge clk) disable iff (!rst_n)
        err_p_o |=> !err_p_o);

    // R4: a blanked pulse produces no output in its error cycle
    a_r4_err_blanks: assert property (@(posedge clk) disable iff (!rst_n)
        err_p_o |-> !pulse_o);

    // R1: outputs are low in the first cycle after reset
    a_r1_reset_quiet: assert property (@(posedge clk)
        $past(!rst_n) |-> (!pulse_o && !err_p_o));

endmodule

// File: tb/tb_burst_heat_guard.sv
module tb_burst_heat_guard;
    import bhg_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int INC  = 10;
    localparam int MAXV = 30;
    localparam int IDLE = 4;
    localparam bhg_decay_t TBL =
        '{32'd0, 32'd1, 32'd1, 32'd1, 32'd1, 32'd1, 32'd1, 32'd1,
          32'd1, 32'd1, 32'd1, 32'd1, 32'd1, 32'd1, 32'd1, 32'd3};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pulse_i = 1'b0, rise_p_i = 1'b0, fall_p_i = 1'b0;
    logic pulse_o, err_p_o;

    burst_heat_guard #(
        .HEAT_INC    (20'(INC)),
        .HEAT_MAX    (40'(MAXV)),
        .IDLE_CYCLES (IDLE),
        .DECAY_STEPS (TBL)
    ) dut (
        .clk (clk), .rst_n (rst_n), .pulse_i (pulse_i),
        .rise_p_i (rise_p_i), .fall_p_i (fall_p_i),
        .pulse_o (pulse_o), .err_p_o (err_p_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        logic  pass;
        logic  err;
        string tag;
    } exp_t;
    exp_t sb[$];
    string cur_tag = "R2";

    // reference model state
    longint m_heat = 0;
    int     m_cyc = 0;
    int     m_idx = 0;
    bit     m_mask = 0;

    task automatic model(input logic p, input logic r, input logic f);
        exp_t e;
        bit ov;
        int nx;
        ov = (m_heat + INC) > MAXV;
        e.pass = p && !(r ? ov : m_mask);
        e.err  = r && ov;
        e.tag  = cur_tag;
        sb.push_back(e);
        if (r) m_mask = ov;
        else if (f) m_mask = 0;
        if (r) begin
            if (!ov) m_heat += INC;
            m_cyc = 0;
            m_idx = 0;
        end else if (!p) begin
            if (m_cyc == IDLE - 1) begin
                m_cyc = 0;
                nx = (m_idx == 15) ? 15 : m_idx + 1;
                m_idx = nx;
                if (m_heat > longint'(TBL[nx])) m_heat -= longint'(TBL[nx]);
                else m_heat = 0;
            end else begin
                m_cyc++;
            end
        end
    endtask

    task automatic drive(input logic p, input logic r, input logic f);
        @(negedge clk);
        pulse_i = p; rise_p_i = r; fall_p_i = f;
        model(p, r, f);
    endtask

    task automatic pulse(input int len, input int gap);
        drive(1, 1, 0);
        for (int i = 1; i < len; i++) drive(1, 0, 0);
        drive(0, 0, 1);
        for (int i = 1; i < gap; i++) drive(0, 0, 0);
    endtask

    task automatic check(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // monitor: pops one expectation per cycle after each edge
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            check(e.tag, "pulse_o", pulse_o, e.pass);
            check(e.tag, "err_p_o", err_p_o, e.err);
        end
    end

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "pulse_o in reset", pulse_o, 1'b0);
        check("R1", "err_p_o in reset", err_p_o, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        cur_tag = "R1";
        model(0, 0, 0);

        // R2 R3 R10: three pulses fill up to exactly the ceiling
        cur_tag = "R10";
        pulse(3, 2);
        pulse(2, 2);
        pulse(5, 2);
        // R4 R5: the fourth is blanked
        cur_tag = "R4";
        pulse(4, 2);
        // R6 R7: three boundaries lower the figure by three; still over
        cur_tag = "R7";
        for (int i = 0; i < 12; i++) drive(0, 0, 0);
        pulse(3, 2);
        // R8: long idle floors the figure at zero; three pass again
        cur_tag = "R8";
        for (int i = 0; i < 200; i++) drive(0, 0, 0);
        pulse(2, 2);
        pulse(2, 2);
        // R9: passed pulse whose end coincides with an over-limit start
        cur_tag = "R9";
        drive(1, 1, 0);
        drive(1, 0, 0);
        drive(1, 0, 0);
        drive(1, 1, 1);
        drive(1, 0, 0);
        drive(1, 0, 0);
        drive(0, 0, 1);
        // R7: sixteen boundaries reach the capped table entry
        cur_tag = "R7";
        for (int i = 0; i < 63; i++) drive(0, 0, 0);
        pulse(2, 2);
        pulse(2, 2);
        pulse(2, 2);
        // R6: counter holds through a long high pulse
        cur_tag = "R6";
        for (int i = 0; i < 40; i++) drive(0, 0, 0);
        pulse(14, 3);
        pulse(2, 6);
        pulse(3, 2);
        // R2: passed pulses of assorted lengths after a full cool-down
        cur_tag = "R2";
        for (int i = 0; i < 150; i++) drive(0, 0, 0);
        pulse(1, 3);
        pulse(7, 3);
        for (int i = 0; i < 4; i++) drive(0, 0, 0);
        wait (sb.size() == 0);
        @(negedge clk);
        finish_run();
    end

endmodule